// File: doc/BRIEF.md
# Synchronous RAM with Selectable Read-During-Write Behaviour

This block is a single-clock memory with one write port and one read port. Writes always land on the rising clock edge. Two compile-time parameters shape the read side. One picks the read path: a combinational path, where data follows the read address within the same cycle, or a registered path, where data appears one edge after the address. The other picks what the read port returns when the read and write addresses are the same in one cycle: the stored value from before the write (old-data mode), the incoming write data (write-through mode), or the previous read output (hold mode).

Old-data mode suits a full FIFO that pushes and pops in the same cycle. The slot being popped gives up its oldest entry while the newest entry replaces it. Write-through mode suits a register file, where a value written in one cycle must reach a reader in that same operation with no added delay. The array holds 2^ADDR_W words of DATA_W bits. Its contents after power-up are undefined. Only the read output register is reset.

Inside the block there is no state machine. A small selector decides each cycle where the next read value comes from:
- ARRAY: the stored word.
- BYPASS: the write data.
- KEEP: the last output.

One shared register captures whichever source the selector picks.

Top module: `sync_rdw_ram`

## Requirements
- R1: A write with wr_en high stores wr_data at wr_addr on the rising edge. A read of that address in any later cycle returns it, in every variant.
- R2: With READ_PATH = PATH_COMB (encoding 0), rd_data shows the word at rd_addr in the same cycle, before the next edge, while rd_en is high.
- R3: With READ_PATH = PATH_REG (encoding 1), rd_data shows the word addressed in a cycle with rd_en high only after the following rising edge.
- R4: With COLL_MODE = COLL_OLD (encoding 0), a read whose address equals the address being written in that cycle returns the contents from before the write.
- R5: With COLL_MODE = COLL_NEW (encoding 1), a read whose address equals the address being written in that cycle returns wr_data.
- R6: With COLL_MODE = COLL_HOLD (encoding 2), rd_data keeps its previous value in any cycle with wr_en high, whatever the two addresses are.
- R7: While rd_en is low, rd_data keeps its previous value in both read paths, even when a write takes place.
- R8: After rst_n is asserted low, rd_data reads 0 until a read is enabled.
- R9: Every one of the 2^ADDR_W addresses, including 0 and the highest, can be written and read.
- R10: In old-data mode, a write and a read of the same slot in one cycle return the older entry. The next read of that slot returns the newer one, as a full FIFO needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset of the read output register |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data |

## Verification
A wrong source choice in the selector shows up at rd_data in the collision cycle itself for the combinational path, and one edge later for the registered path. A stale or corrupted output register shows up as a value that fails to hold, or a value that changes, on the first cycle with rd_en low or with a write in hold mode. A write that lands in the wrong place shows up on the first later read of either address. The bench drives all six variants side by side with the same stimulus. Every collision is therefore observed against all three expected results at once.

// File: rtl/sram_rdw_pkg.sv
`timescale 1ns/1ps
package sram_rdw_pkg;

    typedef enum logic [1:0] {
        COLL_OLD  = 2'd0,
        COLL_NEW  = 2'd1,
        COLL_HOLD = 2'd2
    } coll_mode_e;

    typedef enum logic {
        PATH_COMB = 1'b0,
        PATH_REG  = 1'b1
    } read_path_e;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_BYPASS = 2'd1,
        SRC_KEEP   = 2'd2
    } rd_src_e;

endpackage

// File: rtl/rdw_store.sv
`timescale 1ns/1ps
module rdw_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] raw_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign raw_word = cells[rd_addr];

    // R1: a written word is present at its address after the edge
    p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cells[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/rdw_select.sv
`timescale 1ns/1ps
module rdw_select import sram_rdw_pkg::*; #(
    parameter int         ADDR_W = 8,
    parameter coll_mode_e MODE   = COLL_OLD
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output rd_src_e           src
);
    logic hit;

    always_comb begin
        hit = wr_en && (wr_addr == rd_addr);
        src = SRC_ARRAY;
        if (!rd_en) begin
            src = SRC_KEEP;
        end else begin
            unique case (MODE)
                COLL_OLD:  src = SRC_ARRAY;
                COLL_NEW:  src = hit ? SRC_BYPASS : SRC_ARRAY;
                COLL_HOLD: src = wr_en ? SRC_KEEP : SRC_ARRAY;
                default:   src = SRC_ARRAY;
            endcase
        end
    end

endmodule

// File: rtl/rdw_readport.sv
`timescale 1ns/1ps
module rdw_readport import sram_rdw_pkg::*; #(
    parameter int         DATA_W = 8,
    parameter read_path_e PATH   = PATH_REG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rd_src_e           src,
    input  logic [DATA_W-1:0] raw_word,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] pick;
    logic [DATA_W-1:0] keep_q;
    logic              primed_q;

    always_comb begin
        unique case (src)
            SRC_ARRAY:  pick = raw_word;
            SRC_BYPASS: pick = wr_data;
            SRC_KEEP:   pick = keep_q;
            default:    pick = keep_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keep_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            keep_q   <= pick;
            primed_q <= 1'b1;
        end
    end

    generate
        if (PATH == PATH_REG) begin : g_reg
            assign rd_data = keep_q;

            // R7: a kept cycle leaves the registered output untouched
            p_keep_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
                src == SRC_KEEP |=> $stable(rd_data));
            // R5: bypassed write data appears after the edge
            p_bypass_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
                src == SRC_BYPASS |=> rd_data == $past(wr_data));
            // R3: array word appears one edge after its address
            p_array_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
                src == SRC_ARRAY |=> rd_data == $past(raw_word));
        end else begin : g_comb
            assign rd_data = pick;

            // R7: a kept cycle repeats the previous cycle's output
            p_keep_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
                primed_q && src == SRC_KEEP |-> $stable(rd_data));
            // R5: write-through data is visible in the same cycle
            p_bypass_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
                src == SRC_BYPASS |-> rd_data == wr_data);
        end
    endgenerate

endmodule

// File: rtl/sync_rdw_ram.sv
`timescale 1ns/1ps
module sync_rdw_ram import sram_rdw_pkg::*; #(
    parameter int         DATA_W    = 8,
    parameter int         ADDR_W    = 8,
    parameter coll_mode_e COLL_MODE = COLL_OLD,
    parameter read_path_e READ_PATH = PATH_REG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] raw_word;
    rd_src_e           src;

    rdw_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .raw_word (raw_word)
    );

    rdw_select #(.ADDR_W(ADDR_W), .MODE(COLL_MODE)) u_select (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .src     (src)
    );

    rdw_readport #(.DATA_W(DATA_W), .PATH(READ_PATH)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .raw_word (raw_word),
        .wr_data  (wr_data),
        .rd_data  (rd_data)
    );

    generate
        if (COLL_MODE == COLL_HOLD && READ_PATH == PATH_REG) begin : g_hold_chk
            // R6: any write freezes the registered output in hold mode
            p_write_freezes_r6: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> $stable(rd_data));
        end
        if (COLL_MODE == COLL_OLD && READ_PATH == PATH_REG) begin : g_old_chk
            // R4: a same-address collision returns the pre-write word
            p_old_on_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
                rd_en && wr_en && wr_addr == rd_addr |=> rd_data == $past(raw_word));
        end
    endgenerate

endmodule

// File: tb/sim_sync_rdw_ram.sv
`timescale 1ns/1ps
module sim_sync_rdw_ram;
    import sram_rdw_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] q [6];

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] mdl [256];
    bit         wrote [256];
    logic [7:0] last [6];
    bit         known [6];

    always #4 clk = ~clk;

    // lanes 0..2 registered (old, new, hold); lanes 3..5 combinational
    sync_rdw_ram u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(q[0]));
    sync_rdw_ram #(.COLL_MODE(COLL_NEW), .READ_PATH(PATH_REG)) u1 (.clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(q[1]));
    sync_rdw_ram #(.COLL_MODE(COLL_HOLD), .READ_PATH(PATH_REG)) u2 (.clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(q[2]));
    sync_rdw_ram #(.COLL_MODE(COLL_OLD), .READ_PATH(PATH_COMB)) u3 (.clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(q[3]));
    sync_rdw_ram #(.COLL_MODE(COLL_NEW), .READ_PATH(PATH_COMB)) u4 (.clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(q[4]));
    sync_rdw_ram #(.COLL_MODE(COLL_HOLD), .READ_PATH(PATH_COMB)) u5 (.clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(q[5]));

    task automatic chk(input int lane, input logic [7:0] got, input logic [7:0] exp,
                       input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s lane %0d: got %h expected %h", tag, lane, got, exp);
        end
    endtask

    // One cycle: drive at the falling edge, sample the combinational lanes before
    // the rising edge and the registered lanes at the next falling edge.
    task automatic step(input bit we, input logic [7:0] wa, input logic [7:0] wd,
                        input bit re, input logic [7:0] ra, input string tag);
        logic [7:0] got [6];
        logic [7:0] oldv, newv;
        bit okv, okn, coll;
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        #1;
        for (int k = 3; k < 6; k++) got[k] = q[k];
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 3; k++) got[k] = q[k];
        oldv = mdl[ra];
        okv  = wrote[ra];
        coll = we && (wa == ra);
        newv = coll ? wd : oldv;
        okn  = coll ? 1'b1 : okv;
        for (int p = 0; p < 2; p++) begin
            if (re) begin
                last[3*p] = oldv; known[3*p] = okv;
                last[3*p+1] = newv; known[3*p+1] = okn;
            end
            if (re && !we) begin
                last[3*p+2] = oldv; known[3*p+2] = okv;
            end
        end
        for (int k = 0; k < 6; k++) begin
            if (known[k]) chk(k, got[k], last[k], tag);
        end
        if (we) begin
            mdl[wa] = wd;
            wrote[wa] = 1'b1;
        end
    endtask

    task automatic t_reset();
        step(1'b0, 8'd0, 8'd0, 1'b0, 8'd0, "R8 reset value");
    endtask

    task automatic t_fill();
        step(1'b1, 8'd0,   8'hA0, 1'b0, 8'd0, "R7 idle read during write");
        step(1'b1, 8'd255, 8'hAF, 1'b0, 8'd0, "R7 idle read during write");
        step(1'b1, 8'd7,   8'h17, 1'b0, 8'd0, "R7 idle read during write");
        step(1'b1, 8'd8,   8'h18, 1'b0, 8'd0, "R7 idle read during write");
        step(1'b1, 8'd9,   8'h19, 1'b0, 8'd0, "R7 idle read during write");
        step(1'b1, 8'd100, 8'h64, 1'b0, 8'd0, "R7 idle read during write");
    endtask

    task automatic t_edges();
        step(1'b0, 8'd0, 8'd0, 1'b1, 8'd0,   "R9 lowest address");
        step(1'b0, 8'd0, 8'd0, 1'b1, 8'd255, "R9 highest address");
    endtask

    task automatic t_write_next();
        step(1'b1, 8'd20, 8'h5A, 1'b0, 8'd0,  "R1 write cycle");
        step(1'b0, 8'd0,  8'd0,  1'b1, 8'd20, "R1 visible next cycle");
    endtask

    task automatic t_plain();
        step(1'b0, 8'd0, 8'd0, 1'b1, 8'd7, "R2 R3 plain read");
        step(1'b0, 8'd0, 8'd0, 1'b1, 8'd8, "R2 R3 plain read");
        step(1'b0, 8'd0, 8'd0, 1'b1, 8'd9, "R2 R3 plain read");
    endtask

    task automatic t_same();
        step(1'b1, 8'd8, 8'hC3, 1'b1, 8'd8, "R4 R5 R6 same-address collision");
        step(1'b0, 8'd0, 8'd0,  1'b1, 8'd8, "R1 collided word stored");
    endtask

    task automatic t_other();
        step(1'b0, 8'd0, 8'd0,  1'b1, 8'd7,   "R2 R3 set up");
        step(1'b1, 8'd9, 8'h11, 1'b1, 8'd100, "R6 write elsewhere");
        step(1'b0, 8'd0, 8'd0,  1'b1, 8'd9,   "R1 other write stored");
    endtask

    task automatic t_fifo();
        step(1'b1, 8'd100, 8'hEE, 1'b1, 8'd100, "R10 full fifo push and pop");
        step(1'b0, 8'd0,   8'd0,  1'b1, 8'd100, "R10 newest after pop");
    endtask

    task automatic t_disabled();
        step(1'b1, 8'd7, 8'h77, 1'b0, 8'd7, "R7 read disabled");
        step(1'b0, 8'd0, 8'd0,  1'b0, 8'd9, "R7 read disabled");
        step(1'b0, 8'd0, 8'd0,  1'b1, 8'd7, "R1 R3 after disable");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mdl[i] = '0;
            wrote[i] = 1'b0;
        end
        for (int k = 0; k < 6; k++) begin
            last[k] = '0;
            known[k] = 1'b1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_edges();
        t_write_next();
        t_plain();
        t_same();
        t_other();
        t_fifo();
        t_disabled();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule